// File: doc/BRIEF.md
# Multiword DMA Strobe Timing Generator

This block drives the read and write strobes of a parallel disk interface during a multiword DMA burst. A single 62.5 ns tick clock paces everything, and every strobe uses one of four fixed timing classes. Each class has its own active and recovery length in ticks. The class is either given directly as a code or picked by a priority selector. The selector takes the drive's required active, recovery and cycle times in nanoseconds and returns the fastest class that meets all three limits.

Software loads a configuration while the engine is idle. The configuration holds the class or the required times, the direction, the target channel and the word count. A start pulse then launches the burst. The engine asserts the acknowledge line and issues one strobe per 16-bit word whenever the drive requests. When the count runs out it releases the acknowledge and pulses done. A stop request ends the burst after the strobe in flight and its recovery. One engine serves both channels, so configuration and start are refused while a burst runs.

Top module: `mwdma_strobe_gen`

## Requirements
- R1: With `cfgUseClass`=0 the class is chosen from the given times. Class D (1 tick active, 2 recovery) applies when active ≤ 50 ns, recovery ≤ 375 ns and cycle ≤ 425 ns. Otherwise class C (2/2) applies when active ≤ 125, recovery ≤ 375 and cycle ≤ 500. Otherwise class B (3/4) applies when active ≤ 200, recovery ≤ 550 and cycle ≤ 750. Otherwise class A (4/5) applies.
- R2: With `cfgUseClass`=1 the code on `cfgClass` is used as is, and the times are ignored. The codes are 0=A, 1=B, 2=C, 3=D.
- R3: Each strobe is held low for exactly the class's active ticks. While the request stays high, the next strobe follows after exactly the class's recovery ticks, so one word takes active+recovery cycles.
- R4: A write burst (`cfgIsWrite`=1) pulses only `diowN`. A read burst pulses only `diorN`. The two are never low together.
- R5: A strobe starts only while `dmackN` is low and `dmarq` was high in the previous cycle. With `dmarq` low the engine waits, holding `dmackN` low and both strobes high.
- R6: One word moves per strobe. On reads `ddIn` is captured in the last active cycle, and `rdValid` pulses with it in the next cycle. On writes `wrTake` pulses in the cycle before the strobe, and `ddOut` holds that `wrData` value with `ddOe` high while the strobe is low.
- R7: After the recovery of the last word, `dmackN` rises, `busy` falls, and `done` is high for exactly one cycle. The number of strobes equals `cfgWords`.
- R8: A stop during a strobe or recovery completes that strobe at full width and its recovery, then goes idle without `done`. A stop while waiting for a request goes idle at the next edge.
- R9: `cfgWrite` while busy raises `cfgReject` and leaves the stored configuration unchanged. `start` while busy is ignored.
- R10: `start` with a stored word count of zero leaves the engine idle.
- R11: After reset `dmackN`, `diorN` and `diowN` are high, and `busy`, `done`, `ddOe` and `rdValid` are low.
- R12: `chanSel` shows the configured channel and stays constant for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one period per 62.5 ns tick |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrite | input | 1 | Load configuration (accepted only when idle) |
| cfgUseClass | input | 1 | 1: use cfgClass, 0: select from times |
| cfgClass | input | 2 | Direct class code 0=A 1=B 2=C 3=D |
| cfgActiveNs | input | 10 | Required active time, ns |
| cfgRecoverNs | input | 10 | Required recovery time, ns |
| cfgCycleNs | input | 11 | Required cycle time, ns |
| cfgIsWrite | input | 1 | 1: write burst, 0: read burst |
| cfgChannel | input | 1 | Target channel |
| cfgWords | input | 16 | Words in the burst |
| cfgReject | output | 1 | Configuration write refused (busy) |
| start | input | 1 | Launch a burst |
| stop | input | 1 | Request early end |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the last word |
| chanSel | output | 1 | Channel routed to the engine |
| dmarq | input | 1 | Drive DMA request |
| dmackN | output | 1 | DMA acknowledge, active low |
| diorN | output | 1 | Read strobe, active low |
| diowN | output | 1 | Write strobe, active low |
| ddIn | input | 16 | Data from drive |
| ddOut | output | 16 | Data to drive |
| ddOe | output | 1 | Drive data output enable |
| wrData | input | 16 | Next host word for writes |
| wrTake | output | 1 | wrData consumed this cycle |
| rdData | output | 16 | Word read from drive |
| rdValid | output | 1 | rdData valid pulse |

## Verification
A wrong tick counter or class register shows up on the first strobe of a burst as a low pulse or recovery gap of the wrong length. The bench measures every strobe width and gap at the pins. A miscounting word register shows up only at the end of the burst, as an extra or missing strobe, a missing `done`, or a late acknowledge release. Bursts of several words therefore compare strobe and done counts exactly. A corrupted direction or stop flag is visible within one word, as the wrong strobe pin going low or as strobes continuing past the one in flight.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

  localparam int TICK_PS = 62500;

  typedef enum logic [1:0] {
    CLS_A = 2'd0,
    CLS_B = 2'd1,
    CLS_C = 2'd2,
    CLS_D = 2'd3
  } strobeClass_t;

  // selector limits, ns
  localparam int D_ACT_MAX = 50;
  localparam int D_REC_MAX = 375;
  localparam int D_CYC_MAX = 425;
  localparam int C_ACT_MAX = 125;
  localparam int C_REC_MAX = 375;
  localparam int C_CYC_MAX = 500;
  localparam int B_ACT_MAX = 200;
  localparam int B_REC_MAX = 550;
  localparam int B_CYC_MAX = 750;

  function automatic int activeNs(strobeClass_t c);
    case (c)
      CLS_A:   return 250;
      CLS_B:   return 187;
      CLS_C:   return 125;
      default: return 62;
    endcase
  endfunction

  function automatic int recoverNs(strobeClass_t c);
    case (c)
      CLS_A:   return 312;
      CLS_B:   return 250;
      default: return 125;
    endcase
  endfunction

  // nearest whole tick
  function automatic int nsToTicks(int ns);
    return (ns * 1000 + TICK_PS / 2) / TICK_PS;
  endfunction

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_ACT  = 2'd2,
    S_REC  = 2'd3
  } xferState_t;

  typedef struct packed {
    logic loadCfg;
    logic launch;
    logic loadAct;
    logic loadRec;
    logic wordDone;
    logic captureWr;
  } ctrlStrb_t;

endpackage

// File: rtl/mwdma_class_sel.sv
module mwdma_class_sel
  import mwdma_pkg::*;
#(
  parameter int ACT_W = 10,
  parameter int REC_W = 10,
  parameter int CYC_W = 11
) (
  input  logic [ACT_W-1:0] actNs,
  input  logic [REC_W-1:0] recNs,
  input  logic [CYC_W-1:0] cycNs,
  output strobeClass_t     cls
);
  logic fitsD, fitsC, fitsB;

  always_comb begin
    fitsD = (32'(actNs) <= D_ACT_MAX) && (32'(recNs) <= D_REC_MAX) && (32'(cycNs) <= D_CYC_MAX);
    fitsC = (32'(actNs) <= C_ACT_MAX) && (32'(recNs) <= C_REC_MAX) && (32'(cycNs) <= C_CYC_MAX);
    fitsB = (32'(actNs) <= B_ACT_MAX) && (32'(recNs) <= B_REC_MAX) && (32'(cycNs) <= B_CYC_MAX);
    if (fitsD)      cls = CLS_D;
    else if (fitsC) cls = CLS_C;
    else if (fitsB) cls = CLS_B;
    else            cls = CLS_A;
  end
endmodule

// File: rtl/mwdma_ctrl.sv
module mwdma_ctrl
  import mwdma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWrite,
  input  logic      start,
  input  logic      stop,
  input  logic      dmarq,
  input  logic      tickZero,
  input  logic      wordsZero,
  input  logic      cfgCountZero,
  input  logic      isWrite,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      dmackN,
  output logic      diorN,
  output logic      diowN,
  output logic      ddOe
);
  xferState_t state, stateNext;
  logic stopFlag, stopPend, doneNext;

  assign stopPend = stopFlag | stop;

  always_comb begin
    stateNext = state;
    strb      = '0;
    doneNext  = 1'b0;
    case (state)
      S_IDLE: begin
        strb.loadCfg = cfgWrite;
        if (start && !cfgCountZero) begin
          stateNext   = S_WAIT;
          strb.launch = 1'b1;
        end
      end
      S_WAIT: begin
        if (stopPend) begin
          stateNext = S_IDLE;
        end else if (dmarq) begin
          stateNext      = S_ACT;
          strb.loadAct   = 1'b1;
          strb.captureWr = isWrite;
        end
      end
      S_ACT: begin
        if (tickZero) begin
          stateNext     = S_REC;
          strb.loadRec  = 1'b1;
          strb.wordDone = 1'b1;
        end
      end
      default: begin
        if (tickZero) begin
          if (wordsZero) begin
            stateNext = S_IDLE;
            doneNext  = 1'b1;
          end else if (stopPend) begin
            stateNext = S_IDLE;
          end else if (dmarq) begin
            stateNext      = S_ACT;
            strb.loadAct   = 1'b1;
            strb.captureWr = isWrite;
          end else begin
            stateNext = S_WAIT;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      stopFlag <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      if (state == S_IDLE) stopFlag <= 1'b0;
      else if (stop)       stopFlag <= 1'b1;
    end
  end

  assign busy   = (state != S_IDLE);
  assign dmackN = (state == S_IDLE);
  assign diorN  = !((state == S_ACT) && !isWrite);
  assign diowN  = !((state == S_ACT) && isWrite);
  assign ddOe   = isWrite && ((state == S_ACT) || (state == S_REC));
endmodule

// File: rtl/mwdma_dpath.sv
module mwdma_dpath
  import mwdma_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAN_W = 1,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  strobeClass_t      newClass,
  input  logic              newIsWrite,
  input  logic [CHAN_W-1:0] newChannel,
  input  logic [WORD_W-1:0] newWords,
  input  logic [DATA_W-1:0] ddIn,
  input  logic [DATA_W-1:0] wrData,
  output logic              isWrite,
  output logic [CHAN_W-1:0] chanSel,
  output logic              tickZero,
  output logic              wordsZero,
  output logic              cfgCountZero,
  output logic [DATA_W-1:0] ddOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  strobeClass_t      cls;
  logic [WORD_W-1:0] cfgWords, remaining;
  logic [CNT_W-1:0]  tickCnt, actLoad, recLoad;

  assign actLoad      = CNT_W'(nsToTicks(activeNs(cls)) - 1);
  assign recLoad      = CNT_W'(nsToTicks(recoverNs(cls)) - 1);
  assign tickZero     = (tickCnt == '0);
  assign wordsZero    = (remaining == '0);
  assign cfgCountZero = (cfgWords == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cls      <= CLS_A;
      isWrite  <= 1'b0;
      chanSel  <= '0;
      cfgWords <= '0;
    end else if (strb.loadCfg) begin
      cls      <= newClass;
      isWrite  <= newIsWrite;
      chanSel  <= newChannel;
      cfgWords <= newWords;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      tickCnt   <= '0;
    end else begin
      if (strb.launch)        remaining <= cfgWords;
      else if (strb.wordDone) remaining <= remaining - 1'b1;
      if (strb.loadAct)       tickCnt <= actLoad;
      else if (strb.loadRec)  tickCnt <= recLoad;
      else if (!tickZero)     tickCnt <= tickCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ddOut   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.captureWr) ddOut <= wrData;
      rdValid <= strb.wordDone && !isWrite;
      if (strb.wordDone && !isWrite) rdData <= ddIn;
    end
  end
endmodule

// File: rtl/mwdma_strobe_gen.sv
module mwdma_strobe_gen
  import mwdma_pkg::*;
#(
  parameter int ACT_W  = 10,
  parameter int REC_W  = 10,
  parameter int CYC_W  = 11,
  parameter int WORD_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAN_W = 1,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic              cfgUseClass,
  input  logic [1:0]        cfgClass,
  input  logic [ACT_W-1:0]  cfgActiveNs,
  input  logic [REC_W-1:0]  cfgRecoverNs,
  input  logic [CYC_W-1:0]  cfgCycleNs,
  input  logic              cfgIsWrite,
  input  logic [CHAN_W-1:0] cfgChannel,
  input  logic [WORD_W-1:0] cfgWords,
  output logic              cfgReject,
  input  logic              start,
  input  logic              stop,
  output logic              busy,
  output logic              done,
  output logic [CHAN_W-1:0] chanSel,
  input  logic              dmarq,
  output logic              dmackN,
  output logic              diorN,
  output logic              diowN,
  input  logic [DATA_W-1:0] ddIn,
  output logic [DATA_W-1:0] ddOut,
  output logic              ddOe,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrTake,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  ctrlStrb_t    strb;
  strobeClass_t selClass, newClass;
  logic         isWrite, tickZero, wordsZero, cfgCountZero;

  mwdma_class_sel #(.ACT_W(ACT_W), .REC_W(REC_W), .CYC_W(CYC_W)) u_sel (
    .actNs(cfgActiveNs), .recNs(cfgRecoverNs), .cycNs(cfgCycleNs), .cls(selClass)
  );

  assign newClass  = cfgUseClass ? strobeClass_t'(cfgClass) : selClass;
  assign cfgReject = cfgWrite && busy;
  assign wrTake    = strb.captureWr;

  mwdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .start(start), .stop(stop),
    .dmarq(dmarq), .tickZero(tickZero), .wordsZero(wordsZero),
    .cfgCountZero(cfgCountZero), .isWrite(isWrite), .strb(strb),
    .busy(busy), .done(done), .dmackN(dmackN), .diorN(diorN),
    .diowN(diowN), .ddOe(ddOe)
  );

  mwdma_dpath #(.WORD_W(WORD_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .newClass(newClass),
    .newIsWrite(cfgIsWrite), .newChannel(cfgChannel), .newWords(cfgWords),
    .ddIn(ddIn), .wrData(wrData), .isWrite(isWrite), .chanSel(chanSel),
    .tickZero(tickZero), .wordsZero(wordsZero), .cfgCountZero(cfgCountZero),
    .ddOut(ddOut), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/mwdma_strobe_chk.sv
module mwdma_strobe_chk
  import mwdma_pkg::*;
#(
  parameter int CHAN_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgReject,
  input logic              busy,
  input logic              done,
  input logic [CHAN_W-1:0] chanSel,
  input logic              dmarq,
  input logic              dmackN,
  input logic              diorN,
  input logic              diowN
);
  localparam int MAX_ACT = nsToTicks(activeNs(CLS_A));

  logic strobeLow;
  int   lowRun;
  assign strobeLow = !diorN || !diowN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowRun <= 0;
    else if (strobeLow) lowRun <= lowRun + 1;
    else                lowRun <= 0;
  end

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!diorN && !diowN));
  a_r5_strobe_under_ack: assert property (@(posedge clk) disable iff (!rstN)
    strobeLow |-> !dmackN);
  a_r5_strobe_after_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeLow) |-> $past(dmarq));
  a_r3_active_bounded: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= MAX_ACT);
  a_r7_done_ends_burst: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && dmackN && $past(busy)));
  a_r9_reject_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    cfgReject |-> busy);
  a_r12_channel_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(chanSel));
endmodule

bind mwdma_strobe_gen mwdma_strobe_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgReject(cfgReject), .busy(busy), .done(done),
  .chanSel(chanSel), .dmarq(dmarq), .dmackN(dmackN), .diorN(diorN), .diowN(diowN)
);

// File: tb/test_mwdma_strobe_gen.sv
module test_mwdma_strobe_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 0, cfgUseClass = 0, cfgIsWrite = 0, start = 0, stop = 0, dmarq = 0;
  logic [1:0]  cfgClass = 0;
  logic [9:0]  cfgActiveNs = 0, cfgRecoverNs = 0;
  logic [10:0] cfgCycleNs = 0;
  logic [0:0]  cfgChannel = 0;
  logic [15:0] cfgWords = 0;
  logic [15:0] ddIn, wrData, ddOut, rdData;
  logic cfgReject, busy, done, dmackN, diorN, diowN, ddOe, wrTake, rdValid;
  logic [0:0] chanSel;

  int checks = 0, errors = 0;
  bit finished = 0;

  // port monitor state
  int strobes, curLow, minLow, maxLow, curGap, minGap, maxGap, doneCnt;
  int rdCnt, rdErr, wrErr, wrCount, wrTakes, chanErr;
  bit rdSeen, wrSeen;
  logic [0:0] expChan;

  always #5 clk = ~clk;

  mwdma_strobe_gen i_mwdma_strobe_gen (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgUseClass(cfgUseClass),
    .cfgClass(cfgClass), .cfgActiveNs(cfgActiveNs), .cfgRecoverNs(cfgRecoverNs),
    .cfgCycleNs(cfgCycleNs), .cfgIsWrite(cfgIsWrite), .cfgChannel(cfgChannel),
    .cfgWords(cfgWords), .cfgReject(cfgReject), .start(start), .stop(stop),
    .busy(busy), .done(done), .chanSel(chanSel), .dmarq(dmarq), .dmackN(dmackN),
    .diorN(diorN), .diowN(diowN), .ddIn(ddIn), .ddOut(ddOut), .ddOe(ddOe),
    .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid)
  );

  assign ddIn   = 16'hA000 + 16'(strobes);
  assign wrData = 16'h5000 + 16'(wrCount);

  always @(posedge clk) if (wrTake) begin
    wrCount <= wrCount + 1;
    wrTakes <= wrTakes + 1;
  end

  always @(negedge clk) begin
    if (!diorN) rdSeen = 1;
    if (!diowN) wrSeen = 1;
    if (!diorN || !diowN) begin
      if (curLow == 0 && strobes > 0) begin
        if (curGap < minGap) minGap = curGap;
        if (curGap > maxGap) maxGap = curGap;
      end
      curGap = 0;
      curLow++;
      if (!diowN && (ddOut !== 16'h5000 + 16'(strobes) || !ddOe)) wrErr++;
    end else begin
      if (curLow > 0) begin
        if (curLow < minLow) minLow = curLow;
        if (curLow > maxLow) maxLow = curLow;
        strobes++;
        curLow = 0;
      end
      if (!dmackN && strobes > 0) curGap++;
    end
    if (rdValid) begin
      if (rdData !== 16'hA000 + 16'(rdCnt)) rdErr++;
      rdCnt++;
    end
    if (done) doneCnt++;
    if (busy && chanSel !== expChan) chanErr++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    strobes = 0; curLow = 0; curGap = 0; doneCnt = 0;
    minLow = 1000; maxLow = 0; minGap = 1000; maxGap = 0;
    rdCnt = 0; rdErr = 0; wrErr = 0; wrTakes = 0; chanErr = 0;
    rdSeen = 0; wrSeen = 0;
  endtask

  task automatic configure(input bit useCls, input int cls, input int act, input int rec,
                           input int cyc, input bit wr, input bit ch, input int words);
    @(negedge clk);
    cfgWrite = 1; cfgUseClass = useCls; cfgClass = 2'(cls);
    cfgActiveNs = 10'(act); cfgRecoverNs = 10'(rec); cfgCycleNs = 11'(cyc);
    cfgIsWrite = wr; cfgChannel = ch; cfgWords = 16'(words);
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic runBurst(input int words);
    @(posedge clk); #1; clearMon();
    pulseStart();
    waitIdle();
  endtask

  task automatic t_reset();
    check(dmackN && diorN && diowN, "R11 strobes/ack high", {dmackN, diorN, diowN}, 7);
    check(!busy && !done && !ddOe && !rdValid, "R11 idle outputs", {busy, done, ddOe, rdValid}, 0);
  endtask

  task automatic t_select(input int act, input int rec, input int cyc, input int expA, input int expR,
                          input string tag);
    dmarq = 1;
    configure(0, 0, act, rec, cyc, 0, 0, 3);
    runBurst(3);
    check(minLow == expA && maxLow == expA, {tag, " active ticks"}, maxLow, expA);
    check(minGap == expR && maxGap == expR, {tag, " recovery ticks"}, maxGap, expR);
    check(strobes == 3 && doneCnt == 1, {tag, " R7 count/done"}, strobes * 10 + doneCnt, 31);
  endtask

  task automatic t_classCode();
    dmarq = 1;
    configure(1, 3, 300, 600, 900, 0, 0, 2);
    runBurst(2);
    check(maxLow == 1 && maxGap == 2, "R2 code D overrides times", maxLow * 10 + maxGap, 12);
    configure(1, 0, 10, 10, 10, 0, 0, 2);
    runBurst(2);
    check(maxLow == 4 && maxGap == 5, "R2 code A overrides times", maxLow * 10 + maxGap, 45);
  endtask

  task automatic t_read();
    dmarq = 1;
    configure(1, 2, 0, 0, 0, 0, 0, 5);
    runBurst(5);
    check(rdCnt == 5 && rdErr == 0, "R6 read words captured", rdCnt * 100 + rdErr, 500);
    check(rdSeen && !wrSeen, "R4 read uses read strobe only", {rdSeen, wrSeen}, 2);
    check(wrTakes == 0, "R6 no wrTake on read", wrTakes, 0);
  endtask

  task automatic t_write();
    dmarq = 1;
    configure(1, 2, 0, 0, 0, 1, 0, 4);
    runBurst(4);
    check(wrSeen && !rdSeen, "R4 write uses write strobe only", {rdSeen, wrSeen}, 1);
    check(wrTakes == 4 && wrErr == 0, "R6 write data per strobe", wrTakes * 100 + wrErr, 400);
    check(rdCnt == 0, "R6 no rdValid on write", rdCnt, 0);
    check(strobes == 4 && doneCnt == 1, "R7 write count/done", strobes * 10 + doneCnt, 41);
  endtask

  task automatic t_request();
    dmarq = 0;
    configure(1, 3, 0, 0, 0, 0, 0, 2);
    @(posedge clk); #1; clearMon();
    pulseStart();
    repeat (6) @(negedge clk);
    check(!dmackN && strobes == 0 && curLow == 0, "R5 wait holds ack without strobe",
          strobes, 0);
    dmarq = 1;
    waitIdle();
    check(strobes == 2 && doneCnt == 1 && dmackN, "R7 finish after request", strobes, 2);
  endtask

  task automatic t_stop();
    dmarq = 1;
    configure(1, 0, 0, 0, 0, 0, 0, 10);
    @(posedge clk); #1; clearMon();
    pulseStart();
    while (diorN) @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    waitIdle();
    check(strobes == 1 && maxLow == 4, "R8 stop completes strobe", strobes * 10 + maxLow, 14);
    check(doneCnt == 0 && dmackN, "R8 stop gives no done", doneCnt, 0);
    dmarq = 0;
    @(posedge clk); #1; clearMon();
    pulseStart();
    @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    check(!busy && dmackN && strobes == 0, "R8 stop while waiting", busy, 0);
  endtask

  task automatic t_busyCfg();
    dmarq = 1;
    configure(1, 0, 0, 0, 0, 0, 0, 6);
    @(posedge clk); #1; clearMon();
    pulseStart();
    repeat (3) @(negedge clk);
    cfgWrite = 1; cfgUseClass = 1; cfgClass = 3; cfgWords = 2; cfgIsWrite = 1; start = 1;
    #1;
    check(cfgReject == 1'b1, "R9 reject while busy", cfgReject, 1);
    @(negedge clk); cfgWrite = 0; start = 0;
    waitIdle();
    check(strobes == 6 && maxLow == 4, "R9 burst unchanged", strobes * 10 + maxLow, 64);
    runBurst(6);
    check(strobes == 6 && maxLow == 4 && rdSeen && !wrSeen, "R9 config kept after reject",
          strobes * 10 + maxLow, 64);
  endtask

  task automatic t_zero();
    dmarq = 1;
    configure(1, 3, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1; clearMon();
    pulseStart();
    repeat (4) @(negedge clk);
    check(!busy && dmackN && strobes == 0 && doneCnt == 0, "R10 zero count ignored", busy, 0);
  endtask

  task automatic t_channel();
    dmarq = 1;
    expChan = 1;
    configure(1, 1, 0, 0, 0, 0, 1, 3);
    runBurst(3);
    check(chanSel == 1'b1 && chanErr == 0, "R12 channel held", chanErr, 0);
    check(maxLow == 3 && maxGap == 4, "R2 code B timing", maxLow * 10 + maxGap, 34);
    expChan = 0;
    configure(1, 1, 0, 0, 0, 0, 0, 1);
    check(chanSel == 1'b0, "R12 channel reconfigured", chanSel, 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wrCount = 0; wrTakes = 0; expChan = 0;
    clearMon();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_select(50, 375, 425, 1, 2, "R1 class D limit");
    t_select(51, 100, 200, 2, 2, "R1 class C by active");
    t_select(80, 50, 150, 2, 2, "R1 class C");
    t_select(70, 376, 400, 3, 4, "R1 class B by recovery");
    t_select(100, 100, 501, 3, 4, "R1 class B by cycle");
    t_select(200, 550, 750, 3, 4, "R1 class B limit");
    t_select(201, 50, 300, 4, 5, "R1 class A by active");
    t_select(215, 50, 480, 4, 5, "R1 class A");
    t_classCode();
    t_read();
    t_write();
    t_request();
    t_stop();
    t_busyCfg();
    t_zero();
    t_channel();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end
endmodule